// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulator

This block produces the three classic real-time-clock interrupt causes (once-per-second update, time-of-day alarm and periodic rate) from a free-running counter input and a seconds/minutes/hours time input supplied by a separate timekeeper. A comparator target is held inside the block. When the counter reaches it, the block evaluates every enabled cause and presents a 16-bit flag word with a one-cycle valid strobe.

Software turns on any mix of the update, alarm and periodic causes. It programs an alarm time and picks a periodic rate as a power of two. Rates at or below the 64 Hz base tick are made by dividing the tick count. Faster rates shorten the tick interval itself. If the counter has run more than one interval past the target, the target is walked forward one interval per clock until it is ahead again. Each extra step is a lost tick. Lost ticks are credited to the periodic divider and gathered in a saturating total that software can clear.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset `flag_valid`, `flag_word`, `chan_active` and `lost_cnt` are all zero.
- R2: `chan_active` goes high one cycle after any of `upd_en`, `alm_en`, `per_en` is high and falls one cycle after all are low. On going active the target is set to `count_in` plus the current interval. While no cause is enabled no evaluation takes place and `flag_valid` stays low.
- R3: The interval is `BASE_IVL` counts (the 64 Hz tick). `per_sel` holds log2 of the periodic rate in Hz: 0 is read as 1 and values above 13 are read as 13. With `per_en` high and `per_sel` above 6, the interval is `BASE_IVL >> (per_sel-6)`.
- R4: The update flag is bit 4. It is set at an evaluation when `upd_en` is high, `now_sec` differs from the seconds stored at the previous evaluation, and a stored value exists. The first evaluation after `upd_en` rises only stores the seconds. Dropping `upd_en` discards the stored value.
- R5: The alarm flag is bit 5. It is set when `alm_en` is high and hours, minutes and seconds all equal `alm_hr`, `alm_min`, `alm_sec`.
- R6: The periodic flag is bit 6. For a rate of 64 Hz or less it is set once every 2^(6-per_sel) evaluations. A divider counts the evaluations and is cleared after each flag and while `per_en` is low.
- R7: For a periodic rate above 64 Hz, every evaluation sets bit 6.
- R8: When any of bits 6:4 is set, bit 7 (request) is 1 and bits 15:8 hold 1. Otherwise the whole word is zero. `flag_valid` is a one-cycle pulse for each evaluation.
- R9: A tick is due when the signed difference `count_in - target` is zero or more. The target then advances one interval. On each following cycle in which the counter is still strictly past the target, it advances once more and one lost tick is counted. Evaluation happens on the first cycle the target is not behind, and `flag_valid` follows one cycle later. The lost ticks of that tick are added to the periodic divider together with the tick itself.
- R10: `lost_cnt` adds one for each lost tick, saturates at all ones, and is cleared by `lost_clr`. A clear takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_in | input | CNT_W | Free-running counter |
| upd_en | input | 1 | Update cause enable |
| alm_en | input | 1 | Alarm cause enable |
| per_en | input | 1 | Periodic cause enable |
| per_sel | input | 4 | log2 of periodic rate in Hz |
| now_sec | input | 6 | Current seconds |
| now_min | input | 6 | Current minutes |
| now_hr | input | 6 | Current hours |
| alm_sec | input | 6 | Alarm seconds |
| alm_min | input | 6 | Alarm minutes |
| alm_hr | input | 6 | Alarm hours |
| lost_clr | input | 1 | Clear lost-tick total |
| flag_word | output | 16 | Flag word |
| flag_valid | output | 1 | One-cycle evaluation strobe |
| chan_active | output | 1 | Comparator channel armed |
| lost_cnt | output | LOST_W | Saturating lost-tick total |

## Verification
The counter is stepped forward by random amounts of up to three intervals. This mixes exact-hit ticks, ticks where the target lands on the counter and fires again at once, and ticks with lost steps, so the catch-up path and the periodic credit can be separated from plain ticks. Random enables, rates and time values cover each cause alone and in combination. Directed cases cover the first-sample update suppression, alarms that differ in a single field, the slowest divided rate, a clamped rate code, a channel with all causes off, and a jump of hundreds of intervals that drives the lost total into saturation before it is cleared.

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu #(
  parameter int CNT_W    = 32,
  parameter int BASE_IVL = 1024,
  parameter int LOST_W   = 8,
  parameter int PCNT_W   = 8,
  parameter int TF_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [3:0]        per_sel,
  input  logic [TF_W-1:0]   now_sec,
  input  logic [TF_W-1:0]   now_min,
  input  logic [TF_W-1:0]   now_hr,
  input  logic [TF_W-1:0]   alm_sec,
  input  logic [TF_W-1:0]   alm_min,
  input  logic [TF_W-1:0]   alm_hr,
  input  logic              lost_clr,
  output logic [15:0]       flag_word,
  output logic              flag_valid,
  output logic              chan_active,
  output logic [LOST_W-1:0] lost_cnt
);
  localparam logic [3:0] BASE_LOG2 = 4'd6;
  localparam logic [3:0] SEL_MAX   = 4'd13;
  localparam int         SUM_W     = PCNT_W + LOST_W + 1;
  localparam logic [LOST_W-1:0] LOST_TOP = '1;

  logic              armed, busy, prev_ok;
  logic [CNT_W-1:0]  tgt;
  logic [LOST_W-1:0] run;
  logic [PCNT_W-1:0] pcnt;
  logic [TF_W-1:0]   prev_sec;

  wire active = upd_en | alm_en | per_en;

  logic [3:0] sel_c;
  assign sel_c = (per_sel == 4'd0) ? 4'd1 : (per_sel > SEL_MAX) ? SEL_MAX : per_sel;

  wire fast = per_en && (sel_c > BASE_LOG2);
  logic [3:0] up_sh, dn_sh;
  assign up_sh = fast ? sel_c - BASE_LOG2 : 4'd0;
  assign dn_sh = fast ? 4'd0 : BASE_LOG2 - sel_c;

  logic [CNT_W-1:0] ivl;
  assign ivl = CNT_W'(BASE_IVL) >> up_sh;

  logic [CNT_W-1:0] diff;
  assign diff = count_in - tgt;
  wire due    = !diff[CNT_W-1];
  wire behind = due && (diff != '0);

  wire live  = armed && active;
  wire hit   = live && !busy && due;
  wire catch = live && busy && behind;
  wire eval  = live && busy && !behind;

  logic [SUM_W-1:0] pnext, plim;
  assign pnext = SUM_W'(pcnt) + SUM_W'(run) + SUM_W'(1);
  assign plim  = SUM_W'(1) << dn_sh;

  wire uf = upd_en && prev_ok && (now_sec != prev_sec);
  wire af = alm_en && (now_sec == alm_sec) && (now_min == alm_min) && (now_hr == alm_hr);
  wire pf = per_en && (fast || (pnext >= plim));
  wire any_f = uf | af | pf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      tgt   <= '0;
      run   <= '0;
    end else begin
      armed <= active;
      if (!active) begin
        busy <= 1'b0;
      end else if (!armed) begin
        tgt  <= count_in + ivl;
        busy <= 1'b0;
      end else if (hit) begin
        tgt  <= tgt + ivl;
        busy <= 1'b1;
        run  <= '0;
      end else if (catch) begin
        tgt <= tgt + ivl;
        if (run != LOST_TOP) run <= run + 1'b1;
      end else if (eval) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_valid <= 1'b0;
      flag_word  <= '0;
    end else begin
      flag_valid <= eval;
      if (eval) flag_word <= any_f ? {8'd1, 1'b1, pf, af, uf, 4'b0} : 16'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ok  <= 1'b0;
      prev_sec <= '0;
    end else if (!upd_en) begin
      prev_ok <= 1'b0;
    end else if (eval) begin
      prev_ok  <= 1'b1;
      prev_sec <= now_sec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !per_en) pcnt <= '0;
    else if (eval) pcnt <= pf ? '0 : PCNT_W'(pnext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || lost_clr) lost_cnt <= '0;
    else if (catch && lost_cnt != LOST_TOP) lost_cnt <= lost_cnt + 1'b1;
  end

  assign chan_active = armed;

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |=> !flag_valid);
  // R8
  word_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && (flag_word[6:4] != 3'b0)) |-> (flag_word[15:7] == 9'h003));
  // R8
  word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && (flag_word[6:4] == 3'b0)) |-> (flag_word == 16'd0));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_en || alm_en || per_en) |=> !flag_valid);
  // R10
  lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_clr |=> (lost_cnt == '0));
  // R10
  lost_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost_clr && lost_cnt == LOST_TOP) |=> (lost_cnt == LOST_TOP));
endmodule

// File: tb/rtc_irq_emu_tb_top.sv
module rtc_irq_emu_tb_top;
  localparam int CLK_T = 10;
  localparam int BASE  = 1024;

  logic        clk = 0, rst_n = 0;
  logic [31:0] count_in = 0;
  logic        upd_en = 0, alm_en = 0, per_en = 0, lost_clr = 0;
  logic [3:0]  per_sel = 4'd6;
  logic [5:0]  now_sec = 0, now_min = 0, now_hr = 0, alm_sec = 0, alm_min = 0, alm_hr = 0;
  logic [15:0] flag_word;
  logic        flag_valid, chan_active;
  logic [7:0]  lost_cnt;

  rtc_irq_emu dut_i (.clk(clk), .rst_n(rst_n), .count_in(count_in), .upd_en(upd_en),
    .alm_en(alm_en), .per_en(per_en), .per_sel(per_sel), .now_sec(now_sec),
    .now_min(now_min), .now_hr(now_hr), .alm_sec(alm_sec), .alm_min(alm_min),
    .alm_hr(alm_hr), .lost_clr(lost_clr), .flag_word(flag_word),
    .flag_valid(flag_valid), .chan_active(chan_active), .lost_cnt(lost_cnt));

  always #(CLK_T/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] got_w [32];
  int got_n = 0;
  logic [15:0] exp_w [32];

  logic [31:0] m_tgt;
  bit  m_armed = 0, m_prev_ok = 0;
  logic [5:0] m_prev_sec;
  int  m_pcnt = 0, m_lost = 0;

  always @(negedge clk) if (flag_valid) begin
    if (got_n < 32) got_w[got_n] = flag_word;
    got_n++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sel_clamp(logic [3:0] s);
    return (s == 0) ? 1 : (s > 13) ? 13 : int'(s);
  endfunction

  function automatic logic [31:0] ivl_m();
    int s = sel_clamp(per_sel);
    return (per_en && s > 6) ? 32'(BASE >> (s - 6)) : 32'(BASE);
  endfunction

  task automatic model_eval(input int lost, output logic [15:0] w);
    bit uf, af, pf;
    int s = sel_clamp(per_sel);
    uf = upd_en && m_prev_ok && (now_sec != m_prev_sec);
    if (upd_en) begin m_prev_ok = 1; m_prev_sec = now_sec; end
    af = alm_en && now_sec == alm_sec && now_min == alm_min && now_hr == alm_hr;
    pf = 0;
    if (per_en) begin
      if (s > 6) begin pf = 1; m_pcnt = 0; end
      else begin
        m_pcnt += lost + 1;
        if (m_pcnt >= (1 << (6 - s))) begin pf = 1; m_pcnt = 0; end
      end
    end
    w = (uf | af | pf) ? {8'd1, 1'b1, pf, af, uf, 4'b0} : 16'd0;
  endtask

  task automatic set_cfg(bit u, bit a, bit p, logic [3:0] s);
    @(negedge clk); #1;
    upd_en = u; alm_en = a; per_en = p; per_sel = s;
    if (!u) m_prev_ok = 0;
    if (!p) m_pcnt = 0;
    if (!(u | a | p)) m_armed = 0;
    else if (!m_armed) begin m_armed = 1; m_tgt = count_in + ivl_m(); end
    repeat (3) @(negedge clk);
  endtask

  task automatic step_to(logic [31:0] c, string req);
    int n = 0, cyc = 0;
    @(negedge clk); #1;
    got_n = 0;
    count_in = c;
    if (m_armed) begin
      while ($signed(c - m_tgt) >= 0) begin
        int lost = 0;
        m_tgt += ivl_m();
        while ($signed(c - m_tgt) > 0) begin
          m_tgt += ivl_m(); lost++; cyc++;
          if (m_lost < 255) m_lost++;
        end
        if (n < 32) model_eval(lost > 255 ? 255 : lost, exp_w[n]);
        n++; cyc += 3;
      end
    end
    repeat (cyc + 6) @(negedge clk);
    check({req, " event count"}, got_n, n);
    for (int i = 0; i < n && i < 32 && i < got_n; i++)
      check({req, " flag word"}, got_w[i], exp_w[i]);
    check("R10 lost total", lost_cnt, m_lost);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_T * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    check("R1 valid", flag_valid, 0); check("R1 word", flag_word, 0);
    check("R1 active", chan_active, 0); check("R1 lost", lost_cnt, 0);
    rst_n = 1;
    count_in = 32'd100;
    // R2: nothing enabled, counter runs past
    step_to(32'd5000, "R2 idle");
    check("R2 inactive", chan_active, 0);
    // R4: first sample suppressed, then change
    now_sec = 6'd10;
    set_cfg(1, 0, 0, 4'd6);
    check("R2 armed", chan_active, 1);
    step_to(count_in + BASE, "R4 first sample");
    now_sec = 6'd11;
    step_to(count_in + BASE, "R4 seconds change");
    step_to(count_in + BASE, "R4 seconds same");
    // R5: alarm match and single-field mismatch
    set_cfg(0, 1, 0, 4'd6);
    alm_hr = 6'd3; alm_min = 6'd4; alm_sec = 6'd5;
    now_hr = 6'd3; now_min = 6'd4; now_sec = 6'd5;
    step_to(count_in + BASE, "R5 alarm match");
    now_min = 6'd7;
    step_to(count_in + BASE, "R5 alarm minute differs");
    // R6: 2 Hz -> every 32 ticks
    set_cfg(0, 0, 0, 4'd1);
    set_cfg(0, 0, 1, 4'd1);
    for (int i = 0; i < 33; i++) step_to(count_in + BASE, "R6 slow periodic");
    // R9: lost ticks credited to periodic divider
    step_to(count_in + 3 * BASE + 5, "R9 catch up");
    // R7 and R3: fast rates, clamped code 15
    set_cfg(0, 0, 1, 4'd9);
    step_to(m_tgt, "R7 512 Hz");
    set_cfg(0, 0, 1, 4'd15);
    step_to(m_tgt, "R3 clamped rate");
    step_to(m_tgt + 1, "R3 clamped rate late");
    // R10: saturation and clear
    step_to(count_in + 8 * 300, "R10 saturation");
    check("R10 saturated", lost_cnt, 255);
    @(negedge clk); #1 lost_clr = 1;
    @(negedge clk); #1 lost_clr = 0; m_lost = 0;
    check("R10 cleared", lost_cnt, 0);
    // random mix
    for (int k = 0; k < 200; k++) begin
      if ($urandom_range(0, 5) == 0)
        set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom_range(0, 15)));
      now_sec = 6'($urandom_range(0, 59));
      now_min = 6'($urandom_range(0, 2));
      now_hr  = 6'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin alm_sec = now_sec; alm_min = now_min; alm_hr = now_hr; end
      step_to(count_in + 32'($urandom_range(1, 3 * int'(ivl_m()))), "R8 random mix");
    end
    finish_up();
  end
endmodule